// File: doc/BRIEF.md
# DMA Channel Fault Classifier and First-Error Register

This block watches one channel of a DMA controller. It looks at the channel's configuration fields, the start and continue control writes, the operand address and size of the next bus cycle, the chip-select and interrupt-acknowledge inputs, and the two abort sources. It turns any fault it finds into a 5-bit error code. Only the first fault is kept. While a fault is held, the channel cannot be started.

Software clears the held fault by writing one to the channel's error status bit, which is the `err_clr` pulse. Address alignment is checked before a cycle is granted, so an odd-aligned multi-byte operand never reaches the bus. When a dual-address, device-to-memory transfer has the peripheral control line set up as an abort input, the device's DONE input opens a window in which edges on that line are ignored. The window stays open until the channel is started again.

Top module: `dma_fault_logger`

## Requirements
- R1: A start write (`ctl_wr` with `ctl_start`=1) logs code 0x01 if any of these reserved encodings is present: `cfg_opsize`=11, `cfg_chain`=01, `cfg_dev_step`=11, `cfg_mem_step`=11, `cfg_req_mode`=01.
- R2: A control write with `ctl_cont`=1 logs code 0x02 if `ctl_start` is 0 in the same write or if `chan_active` is 0.
- R3: When `cyc_req` is high, `cfg_opsize` is 01 (word) or 10 (long) and `op_addr[0]`=1, code 0x05 is logged and `cyc_go` stays low in that same cycle. With `cfg_opsize`=00 (byte), any address is accepted.
- R4: When `cs_in` or `iack_in` is high while `bus_master` is high, code 0x06 is logged.
- R5: When `cfg_pctl_abort`=1, a falling edge on `pctl_in` logs code 0x11. A pulse on `soft_abort` logs code 0x10.
- R6: A start write with `cfg_pctl_abort`=1 and `pctl_stat`=1 logs code 0x11 and does not start the channel.
- R7: The ignore window opens when `dev_done` is seen while `chan_active`, `cfg_dual_addr`, `cfg_dev_to_mem` and `cfg_pctl_abort` are all 1. While the window is open, `pctl_in` edges log nothing. The window closes when a start is accepted.
- R8: While a code is held, later faults do not change `err_code`.
- R9: `start_inhibit` equals the pending flag. A start write while a code is held gives no `start_go` and does not log a code 0x02.
- R10: `err_clr` returns `err_code` to 0. A fault in the same cycle as `err_clr` is logged instead.
- R11: When faults occur together, the code logged follows this priority, highest first: 0x01, 0x02, 0x05, 0x06, 0x11, 0x10. `start_go` pulses for a start write only when no code is held and none of the faults in R1, R2 or R6 is present.
- R12: After reset, `err_code`=0, `err_pend`=0 and `start_inhibit`=0, and the ignore window is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_req_mode | input | 2 | Request mode field (01 reserved) |
| cfg_mem_step | input | 2 | Memory address count mode (11 reserved) |
| cfg_dev_step | input | 2 | Device address count mode (11 reserved) |
| cfg_chain | input | 2 | Chaining mode (01 reserved) |
| cfg_opsize | input | 2 | Operand size: 00 byte, 01 word, 10 long, 11 reserved |
| cfg_dual_addr | input | 1 | Dual-address transfer mode |
| cfg_dev_to_mem | input | 1 | Direction is device to memory |
| cfg_pctl_abort | input | 1 | Peripheral control line used as abort input |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_start | input | 1 | Start bit value in the write |
| ctl_cont | input | 1 | Continue bit value in the write |
| soft_abort | input | 1 | Software abort request pulse |
| chan_active | input | 1 | Channel is active |
| pctl_in | input | 1 | Peripheral control line level |
| pctl_stat | input | 1 | Peripheral control transition status bit |
| dev_done | input | 1 | Device DONE input |
| cyc_req | input | 1 | Request to issue an operand bus cycle |
| op_addr | input | ADDR_W | Operand address |
| bus_master | input | 1 | Controller owns the bus |
| cs_in | input | 1 | Chip select to the controller |
| iack_in | input | 1 | Interrupt acknowledge to the controller |
| err_clr | input | 1 | Write-one-to-clear of the error status |
| err_code | output | 5 | Held error code, 0 = none |
| err_pend | output | 1 | An error is held |
| start_inhibit | output | 1 | Channel start is blocked |
| start_go | output | 1 | Start accepted this cycle |
| cyc_go | output | 1 | Operand cycle may proceed |

## Verification
The bench first drives fault pairs into a single cycle, to catch a priority encoder that is wrong or reversed. It drives a second fault while a code is held, which would catch a register that overwrites. It drives a start while a code is held, which exposes a design that starts anyway or logs a timing fault. It also runs a DONE-then-edge sequence, to catch a window that never opens, and a restart after the window, to catch a window that never closes and so loses every later abort. An odd word address paired with a byte operand separates a design that over-blocks from one that lets a misaligned cycle onto the bus.

// File: rtl/dflt_pkg.sv
package dflt_pkg;
  localparam int CODE_W = 5;
  typedef logic [CODE_W-1:0] code_t;
  localparam code_t C_NONE    = 5'h00;
  localparam code_t C_CFG     = 5'h01;
  localparam code_t C_OPTIME  = 5'h02;
  localparam code_t C_ALIGN   = 5'h05;
  localparam code_t C_BUSADR  = 5'h06;
  localparam code_t C_EXTABT  = 5'h11;
  localparam code_t C_SWABT   = 5'h10;

  typedef struct packed {
    logic cfg;
    logic optime;
    logic align;
    logic busadr;
    logic extabt;
    logic swabt;
  } fault_t;
endpackage

// File: rtl/dflt_cfg_check.sv
module dflt_cfg_check (
  input  logic [1:0] req_mode,
  input  logic [1:0] mem_step,
  input  logic [1:0] dev_step,
  input  logic [1:0] chain,
  input  logic [1:0] opsize,
  output logic       reserved
);
  always_comb begin
    reserved = (opsize == 2'b11) | (chain == 2'b01) | (dev_step == 2'b11)
             | (mem_step == 2'b11) | (req_mode == 2'b01);
  end
endmodule

// File: rtl/dflt_abort_track.sv
module dflt_abort_track (
  input  logic clk,
  input  logic rst_n,
  input  logic abort_mode,
  input  logic dual_addr,
  input  logic dev_to_mem,
  input  logic chan_active,
  input  logic dev_done,
  input  logic pctl_in,
  input  logic restart,
  output logic edge_abort
);
  logic pctl_q, pctl_q_nx;
  logic mask_q, mask_nx;
  logic open_win;

  always_comb begin
    open_win   = abort_mode & dual_addr & dev_to_mem & chan_active & dev_done;
    mask_nx    = restart ? 1'b0 : (mask_q | open_win);
    pctl_q_nx  = pctl_in;
    edge_abort = abort_mode & pctl_q & ~pctl_in & ~mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pctl_q <= 1'b1;
      mask_q <= 1'b0;
    end else begin
      pctl_q <= pctl_q_nx;
      mask_q <= mask_nx;
    end
  end
endmodule

// File: rtl/dflt_err_log.sv
module dflt_err_log
  import dflt_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  fault_t fault,
  input  logic   clr,
  output code_t  code
);
  code_t code_q, code_nx, prio;
  logic  pend;
  logic  ld_en;

  always_comb begin
    if      (fault.cfg)    prio = C_CFG;
    else if (fault.optime) prio = C_OPTIME;
    else if (fault.align)  prio = C_ALIGN;
    else if (fault.busadr) prio = C_BUSADR;
    else if (fault.extabt) prio = C_EXTABT;
    else if (fault.swabt)  prio = C_SWABT;
    else                   prio = C_NONE;
    pend    = (code_q != C_NONE) & ~clr;
    ld_en   = ~pend;
    code_nx = ld_en ? prio : code_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= C_NONE;
    else        code_q <= code_nx;
  end

  assign code = code_q;
endmodule

// File: rtl/dma_fault_logger.sv
module dma_fault_logger
  import dflt_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_req_mode,
  input  logic [1:0]        cfg_mem_step,
  input  logic [1:0]        cfg_dev_step,
  input  logic [1:0]        cfg_chain,
  input  logic [1:0]        cfg_opsize,
  input  logic              cfg_dual_addr,
  input  logic              cfg_dev_to_mem,
  input  logic              cfg_pctl_abort,
  input  logic              ctl_wr,
  input  logic              ctl_start,
  input  logic              ctl_cont,
  input  logic              soft_abort,
  input  logic              chan_active,
  input  logic              pctl_in,
  input  logic              pctl_stat,
  input  logic              dev_done,
  input  logic              cyc_req,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic              bus_master,
  input  logic              cs_in,
  input  logic              iack_in,
  input  logic              err_clr,
  output logic [4:0]        err_code,
  output logic              err_pend,
  output logic              start_inhibit,
  output logic              start_go,
  output logic              cyc_go
);
  logic   cfg_bad, edge_abort, start_try, cont_try, multi_byte, stat_abort;
  fault_t fault;
  code_t  code;

  dflt_cfg_check u_cfg (
    .req_mode (cfg_req_mode),
    .mem_step (cfg_mem_step),
    .dev_step (cfg_dev_step),
    .chain    (cfg_chain),
    .opsize   (cfg_opsize),
    .reserved (cfg_bad)
  );

  dflt_abort_track u_abt (
    .clk         (clk),
    .rst_n       (rst_n),
    .abort_mode  (cfg_pctl_abort),
    .dual_addr   (cfg_dual_addr),
    .dev_to_mem  (cfg_dev_to_mem),
    .chan_active (chan_active),
    .dev_done    (dev_done),
    .pctl_in     (pctl_in),
    .restart     (start_go),
    .edge_abort  (edge_abort)
  );

  always_comb begin
    start_try    = ctl_wr & ctl_start;
    cont_try     = ctl_wr & ctl_cont;
    multi_byte   = (cfg_opsize == 2'b01) | (cfg_opsize == 2'b10);
    stat_abort   = start_try & cfg_pctl_abort & pctl_stat;
    fault.cfg    = start_try & cfg_bad;
    fault.optime = cont_try & (~ctl_start | ~chan_active);
    fault.align  = cyc_req & multi_byte & op_addr[0];
    fault.busadr = bus_master & (cs_in | iack_in);
    fault.extabt = edge_abort | stat_abort;
    fault.swabt  = soft_abort;
  end

  dflt_err_log u_log (
    .clk   (clk),
    .rst_n (rst_n),
    .fault (fault),
    .clr   (err_clr),
    .code  (code)
  );

  always_comb begin
    err_code      = code;
    err_pend      = (code != C_NONE);
    start_inhibit = err_pend;
    start_go      = start_try & ~err_pend & ~fault.cfg & ~fault.optime & ~stat_abort;
    cyc_go        = cyc_req & ~fault.align & ~err_pend;
  end
endmodule

// File: rtl/dma_fault_logger_chk.sv
module dma_fault_logger_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        cfg_req_mode,
  input logic [1:0]        cfg_opsize,
  input logic              cfg_pctl_abort,
  input logic              ctl_wr,
  input logic              ctl_start,
  input logic              soft_abort,
  input logic              cyc_req,
  input logic [ADDR_W-1:0] op_addr,
  input logic              bus_master,
  input logic              err_clr,
  input logic [4:0]        err_code,
  input logic              err_pend,
  input logic              start_go,
  input logic              cyc_go
);
  AST_FIRST_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (err_pend && !err_clr) |=> $stable(err_code)); // R8

  AST_NO_START_WHEN_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    err_pend |-> !start_go); // R9

  AST_NO_ODD_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_go |-> !(op_addr[0] && (cfg_opsize == 2'b01 || cfg_opsize == 2'b10))); // R3

  AST_CFG_LOGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_pend && ctl_wr && ctl_start && cfg_req_mode == 2'b01) |=> err_code == 5'h01); // R1

  AST_SOFT_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_pend && soft_abort && !ctl_wr && !cyc_req && !bus_master && !cfg_pctl_abort)
      |=> err_code == 5'h10); // R5
endmodule

bind dma_fault_logger dma_fault_logger_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/dma_fault_logger_bench.sv
module dma_fault_logger_bench;
  localparam int AW = 24;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] req_mode, mem_step, dev_step, chain, opsize;
  logic dual, d2m, pabt, wr, st, cont, sabt, act, pin, pstat, done, creq, bm, cs, iack, clr;
  logic [AW-1:0] addr;
  logic [4:0] code;
  logic pend, inhibit, sgo, cgo;
  int total = 0, bad = 0, cycles = 0;
  logic [4:0] m_code;
  logic m_mask, m_pq;

  dma_fault_logger #(.ADDR_W(AW)) u_dma_fault_logger (
    .clk(clk), .rst_n(rst_n), .cfg_req_mode(req_mode), .cfg_mem_step(mem_step),
    .cfg_dev_step(dev_step), .cfg_chain(chain), .cfg_opsize(opsize),
    .cfg_dual_addr(dual), .cfg_dev_to_mem(d2m), .cfg_pctl_abort(pabt),
    .ctl_wr(wr), .ctl_start(st), .ctl_cont(cont), .soft_abort(sabt),
    .chan_active(act), .pctl_in(pin), .pctl_stat(pstat), .dev_done(done),
    .cyc_req(creq), .op_addr(addr), .bus_master(bm), .cs_in(cs), .iack_in(iack),
    .err_clr(clr), .err_code(code), .err_pend(pend), .start_inhibit(inhibit),
    .start_go(sgo), .cyc_go(cgo));

  always #4 clk = ~clk;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act_v, input int exp_v);
    total++;
    if (act_v != exp_v) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act_v, exp_v);
    end
  endtask

  function automatic logic cfg_res();
    return opsize == 2'b11 || chain == 2'b01 || dev_step == 2'b11 ||
           mem_step == 2'b11 || req_mode == 2'b01;
  endfunction

  function automatic logic [4:0] exp_fault();
    logic s = wr & st;
    if (s && cfg_res())                                   return 5'h01;
    if (wr && cont && (!st || !act))                      return 5'h02;
    if (creq && (opsize == 2'b01 || opsize == 2'b10) && addr[0]) return 5'h05;
    if (bm && (cs || iack))                               return 5'h06;
    if ((pabt && m_pq && !pin && !m_mask) || (s && pabt && pstat)) return 5'h11;
    if (sabt)                                             return 5'h10;
    return 5'h00;
  endfunction

  function automatic logic exp_sgo();
    return wr && st && m_code == 0 && !cfg_res() && !(cont && !act) && !(pabt && pstat);
  endfunction

  task automatic idle();
    req_mode = 0; mem_step = 0; dev_step = 0; chain = 0; opsize = 0;
    dual = 0; d2m = 0; pabt = 0; wr = 0; st = 0; cont = 0; sabt = 0; act = 0;
    pin = 1; pstat = 0; done = 0; creq = 0; bm = 0; cs = 0; iack = 0; clr = 0; addr = 0;
  endtask

  // inputs already set by caller before the negedge window ends
  task automatic step(input string tag);
    logic [4:0] f;
    logic g;
    #1;
    f = exp_fault();
    g = exp_sgo();
    chk({tag, " start_go"}, sgo, g);
    chk({tag, " cyc_go"}, cgo, creq && !(creq && (opsize == 2'b01 || opsize == 2'b10) && addr[0]) && m_code == 0);
    chk({tag, " inhibit"}, inhibit, m_code != 0);
    if (clr || m_code == 0) m_code = f;
    m_mask = g ? 1'b0 : (m_mask | (pabt && dual && d2m && act && done));
    m_pq = pin;
    @(posedge clk); #1;
    chk({tag, " code"}, code, m_code);
    chk({tag, " pend"}, pend, m_code != 0);
    @(negedge clk);
    idle();
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    idle();
    m_code = 0; m_mask = 0; m_pq = 1;
    #20; @(negedge clk); rst_n = 1'b1;
    #1; chk("R12 code", code, 0); chk("R12 pend", pend, 0); chk("R12 inhibit", inhibit, 0);
    @(negedge clk);
    // R1 reserved config on start
    wr = 1; st = 1; chain = 2'b01; step("R1");
    // R9 start while pending
    wr = 1; st = 1; step("R9");
    // R8 later fault ignored
    sabt = 1; bm = 1; cs = 1; step("R8");
    clr = 1; step("R10");
    // R2 continue without start
    wr = 1; cont = 1; step("R2");
    clr = 1; creq = 1; opsize = 2'b01; addr = 24'h000101; step("R10 R3");
    clr = 1; step("R10");
    creq = 1; opsize = 2'b00; addr = 24'h000003; step("R3 byte");
    bm = 1; iack = 1; step("R4");
    clr = 1; step("R10");
    // R5 edge abort
    pabt = 1; pin = 1; step("R5 pre");
    pabt = 1; pin = 0; step("R5 edge");
    clr = 1; sabt = 1; step("R5 soft");
    clr = 1; step("R10");
    // R6 start with status set
    wr = 1; st = 1; pabt = 1; pstat = 1; step("R6");
    clr = 1; step("R10");
    // R11 priority: optime beats misalign and abort
    wr = 1; cont = 1; creq = 1; opsize = 2'b10; addr = 24'h1; sabt = 1; step("R11");
    clr = 1; step("R10");
    // R7 window
    pabt = 1; dual = 1; d2m = 1; act = 1; done = 1; step("R7 open");
    pabt = 1; pin = 0; step("R7 masked");
    wr = 1; st = 1; act = 1; step("R7 restart");
    pabt = 1; pin = 1; step("R7 high");
    pabt = 1; pin = 0; step("R7 abort back");
    clr = 1; step("R10");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      req_mode = 2'($urandom_range(0, 7) == 0 ? 1 : 0);
      chain    = 2'($urandom_range(0, 7) == 0 ? 1 : 0);
      opsize   = 2'($urandom_range(0, 3));
      mem_step = 2'($urandom_range(0, 2)); dev_step = 2'($urandom_range(0, 2));
      dual = 1'($urandom); d2m = 1'($urandom); pabt = 1'($urandom);
      wr = 1'($urandom); st = 1'($urandom); cont = 1'($urandom_range(0, 3) == 0);
      sabt = 1'($urandom_range(0, 7) == 0); act = 1'($urandom);
      pin = 1'($urandom); pstat = 1'($urandom_range(0, 3) == 0);
      done = 1'($urandom_range(0, 7) == 0); creq = 1'($urandom);
      addr = AW'($urandom); bm = 1'($urandom);
      cs = 1'($urandom_range(0, 7) == 0); iack = 1'($urandom_range(0, 7) == 0);
      clr = 1'($urandom_range(0, 2) == 0);
      step("R8 R11 random");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule